// File: doc/BRIEF.md
# Receive Trigger Interrupt and Line Status Unit

This unit gathers the interrupt sources of a byte-oriented serial port and turns them into one interrupt request, a four-bit interrupt status code and an eight-bit line status word. It holds a four-bit interrupt enable register. The receive-data source is a level condition: the receive FIFO occupancy is compared against a trigger level picked by a two-bit field. The request drops by itself as soon as the occupancy falls below that level; no status read is needed.

Receive errors arrive as single-cycle event flags and are kept in sticky line-status bits until the CPU reads the line status. Transmit-empty and modem-change sources are plain level inputs gated by their enable bits. When the FIFO is enabled and every enable bit is clear, the unit reports polled mode and never raises the request. The CPU then works from the line status word alone.

Top module: `rx_irq_status_unit`

## Requirements
- R1: After reset the enable register reads 0000, the line-status error bits (lsr[4:1]) are 0, irq is low and int_code is 4'b0001.
- R2: A cycle with ier_wr high loads ier_wdata[3:0] into the enable register at that clock edge. Bit 0 enables receive data, bit 1 transmit empty, bit 2 line status and bit 3 modem change.
- R3: With fifo_en high, trig_sel selects the receive trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. The receive source is pending when rx_count is at or above the level and enable bit 0 is set. With fifo_en low the level is 1 whatever trig_sel holds.
- R4: While the receive source is the reported one, int_code is 4'b0100. irq and the code fall in the same cycle that rx_count drops below the trigger level, with no register in between.
- R5: err_evt bits 0..3 (overrun, parity, framing, break) set lsr bits 1..4 at the next clock edge. The bits stay set until a cycle with lsr_rd high clears them. A new event in the same cycle as lsr_rd wins.
- R6: The line-status source is pending when enable bit 2 is set and any of lsr[4:1] is 1. Its code is 4'b0110.
- R7: The transmit-empty source is pending when enable bit 1 is set and tx_fifo_empty is high. Its code is 4'b0010.
- R8: The modem source is pending when enable bit 3 is set and modem_pend is high. Its code is 4'b0000.
- R9: int_code reports the highest-priority pending source, in the order line status, receive data, transmit empty, modem.
- R10: irq is the OR of all enabled pending sources, updated combinationally. When nothing is pending, int_code is 4'b0001.
- R11: With fifo_en high and all four enable bits clear, polled is high and irq stays low whatever the sources do.
- R12: lsr[0] is 1 when rx_count is non-zero, lsr[5] equals tx_fifo_empty, lsr[6] is tx_fifo_empty AND tx_shift_empty, and lsr[7] is rx_err_any while fifo_en is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 4 | Enable bits to load |
| ier_q | output | 4 | Current enable register |
| fifo_en | input | 1 | FIFO mode enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W (5) | Receive FIFO occupancy |
| rx_err_any | input | 1 | Some byte held in the receive FIFO has an error |
| err_evt | input | 4 | Receive error events: overrun, parity, framing, break |
| lsr_rd | input | 1 | Line status read, clears the sticky error bits |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| modem_pend | input | 1 | Modem status change pending |
| irq | output | 1 | Interrupt request |
| int_code | output | 4 | Interrupt status code |
| lsr | output | 8 | Line status word |
| polled | output | 1 | Polled mode indication |

## Verification
The assertions assume that rx_count never exceeds the FIFO depth and that the inputs are steady from a little after each falling edge until the next rising edge. The bench therefore changes inputs only just after a falling edge and keeps every occupancy value between 0 and 16. Error events are driven as one-cycle pulses, as the receiver would produce them. The pulses are timed against lsr_rd so that both orders, and the same-cycle collision, are seen.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

   localparam int SRC_N = 4;
   localparam int ERR_N = 4;

   // Source order equals priority: index 0 is reported first.
   localparam int SRC_LINE = 0;
   localparam int SRC_RXD  = 1;
   localparam int SRC_TXE  = 2;
   localparam int SRC_MDM  = 3;

   typedef enum logic [3:0] {
      CODE_MDM  = 4'b0000,
      CODE_NONE = 4'b0001,
      CODE_TXE  = 4'b0010,
      CODE_RXD  = 4'b0100,
      CODE_LINE = 4'b0110
   } int_code_e;

   function automatic int_code_e src_code(input int idx);
      case (idx)
         SRC_LINE: return CODE_LINE;
         SRC_RXD:  return CODE_RXD;
         SRC_TXE:  return CODE_TXE;
         default:  return CODE_MDM;
      endcase
   endfunction

endpackage

// File: rtl/isu_enable_reg.sv
module isu_enable_reg #(
   parameter int EN_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [EN_W-1:0] wr_data,
   output logic [EN_W-1:0] en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= wr_data;
   end

   // R2
   ier_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> en_q == $past(wr_data));

   // R2
   ier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q));

endmodule

// File: rtl/isu_trig_cmp.sv
module isu_trig_cmp #(
   parameter int CNT_W  = 5,
   parameter int TRIG_A = 1,
   parameter int TRIG_B = 4,
   parameter int TRIG_C = 8,
   parameter int TRIG_D = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] count,
   output logic             at_trig
);

   localparam logic [CNT_W-1:0] LVL_A = CNT_W'(TRIG_A);
   localparam logic [CNT_W-1:0] LVL_B = CNT_W'(TRIG_B);
   localparam logic [CNT_W-1:0] LVL_C = CNT_W'(TRIG_C);
   localparam logic [CNT_W-1:0] LVL_D = CNT_W'(TRIG_D);
   localparam logic [CNT_W-1:0] LVL_1 = CNT_W'(1);

   logic [CNT_W-1:0] level;

   always_comb begin
      if (!fifo_en) level = LVL_1;
      else begin
         case (sel)
            2'd0:    level = LVL_A;
            2'd1:    level = LVL_B;
            2'd2:    level = LVL_C;
            default: level = LVL_D;
         endcase
      end
      at_trig = (count >= level);
   end

   // R3
   trig_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_trig |-> count != '0);

   // R3
   trig_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && count >= LVL_D) |-> at_trig);

endmodule

// File: rtl/isu_line_sticky.sv
module isu_line_sticky #(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] evt,
   input  logic             clr,
   output logic [ERR_W-1:0] err_q
);

   for (genvar gi = 0; gi < ERR_W; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       err_q[gi] <= 1'b0;
         else if (evt[gi]) err_q[gi] <= 1'b1;
         else if (clr)     err_q[gi] <= 1'b0;
      end

      // R5
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[gi] |=> err_q[gi]);

      // R5
      sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !evt[gi]) |=> !err_q[gi]);

      // R5
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !evt[gi]) |=> $stable(err_q[gi]));
   end

endmodule

// File: rtl/isu_prio.sv
module isu_prio
   import irqs_pkg::*;
#(
   parameter int N = SRC_N
) (
   input  logic [N-1:0] pend,
   output int_code_e    code,
   output logic         any
);

   always_comb begin
      code = CODE_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) code = src_code(i);
      end
      any = |pend;
   end

endmodule

// File: rtl/rx_irq_status_unit.sv
module rx_irq_status_unit
   import irqs_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TRIG_A     = 1,
   parameter int TRIG_B     = 4,
   parameter int TRIG_C     = 8,
   parameter int TRIG_D     = 14,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ier_wr,
   input  logic [3:0]       ier_wdata,
   output logic [3:0]       ier_q,
   input  logic             fifo_en,
   input  logic [1:0]       trig_sel,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_err_any,
   input  logic [3:0]       err_evt,
   input  logic             lsr_rd,
   input  logic             tx_fifo_empty,
   input  logic             tx_shift_empty,
   input  logic             modem_pend,
   output logic             irq,
   output logic [3:0]       int_code,
   output logic [7:0]       lsr,
   output logic             polled
);

   if (TRIG_A < 1 || TRIG_B <= TRIG_A || TRIG_C <= TRIG_B || TRIG_D <= TRIG_C)
   begin : g_bad_order
      $error("trigger levels must be ascending and at least 1");
   end
   if (TRIG_D > FIFO_DEPTH) begin : g_bad_depth
      $error("trigger level exceeds FIFO depth");
   end

   logic [ERR_N-1:0] err_q;
   logic             at_trig;
   logic [SRC_N-1:0] pend;
   int_code_e        code;
   logic             any_pend;

   isu_enable_reg #(.EN_W(4)) u_ier (
      .clk(clk), .rst_n(rst_n), .wr_en(ier_wr), .wr_data(ier_wdata), .en_q(ier_q)
   );

   isu_trig_cmp #(
      .CNT_W(CNT_W), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B), .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
   ) u_trig (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sel(trig_sel),
      .count(rx_count), .at_trig(at_trig)
   );

   isu_line_sticky #(.ERR_W(ERR_N)) u_sticky (
      .clk(clk), .rst_n(rst_n), .evt(err_evt), .clr(lsr_rd), .err_q(err_q)
   );

   always_comb begin
      pend[SRC_LINE] = ier_q[2] & (|err_q);
      pend[SRC_RXD]  = ier_q[0] & at_trig;
      pend[SRC_TXE]  = ier_q[1] & tx_fifo_empty;
      pend[SRC_MDM]  = ier_q[3] & modem_pend;
   end

   isu_prio #(.N(SRC_N)) u_prio (.pend(pend), .code(code), .any(any_pend));

   always_comb begin
      irq      = any_pend;
      int_code = code;
      polled   = fifo_en & (ier_q == 4'b0000);
      lsr      = {fifo_en & rx_err_any,
                  tx_fifo_empty & tx_shift_empty,
                  tx_fifo_empty,
                  err_q,
                  rx_count != '0};
   end

   // R10
   irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> int_code != CODE_NONE);

   // R10
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> int_code == CODE_NONE);

   // R11
   polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      polled |-> !irq);

   // R9
   line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q[2] && lsr[4:1] != 4'b0000) |-> int_code == CODE_LINE);

   // R4
   rxd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_code == CODE_RXD |-> (ier_q[0] && lsr[0]));

endmodule

// File: tb/sim_rx_irq_status_unit.sv
`timescale 1ns/1ps
module sim_rx_irq_status_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ier_wr = 1'b0;
   logic [3:0] ier_wdata = '0;
   logic [3:0] ier_q;
   logic       fifo_en = 1'b1;
   logic [1:0] trig_sel = '0;
   logic [4:0] rx_count = '0;
   logic       rx_err_any = 1'b0;
   logic [3:0] err_evt = '0;
   logic       lsr_rd = 1'b0;
   logic       tx_fifo_empty = 1'b0;
   logic       tx_shift_empty = 1'b0;
   logic       modem_pend = 1'b0;
   logic       irq;
   logic [3:0] int_code;
   logic [7:0] lsr;
   logic       polled;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   rx_irq_status_unit u0 (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_q(ier_q),
      .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count), .rx_err_any(rx_err_any),
      .err_evt(err_evt), .lsr_rd(lsr_rd), .tx_fifo_empty(tx_fifo_empty),
      .tx_shift_empty(tx_shift_empty), .modem_pend(modem_pend), .irq(irq),
      .int_code(int_code), .lsr(lsr), .polled(polled)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Inputs change just after a falling edge; checks sample 2 ns later.
   task automatic settle();
      #2;
   endtask

   task automatic set_ier(input logic [3:0] v);
      @(negedge clk);
      ier_wr = 1'b1; ier_wdata = v;
      @(negedge clk);
      ier_wr = 1'b0;
      settle();
   endtask

   task automatic pulse_err(input logic [3:0] e, input logic rd);
      @(negedge clk);
      err_evt = e; lsr_rd = rd;
      @(negedge clk);
      err_evt = '0; lsr_rd = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      chk(ier_q, 4'b0000, "R1 enable reg");
      chk(lsr[4:1], 4'b0000, "R1 error bits");
      chk(irq, 1'b0, "R1 irq");
      chk(int_code, 4'b0001, "R1 code");
   endtask

   task automatic t_ier_write();
      set_ier(4'b1010);
      chk(ier_q, 4'b1010, "R2 load 1010");
      set_ier(4'b0101);
      chk(ier_q, 4'b0101, "R2 load 0101");
      @(negedge clk); ier_wdata = 4'b1111; settle();
      chk(ier_q, 4'b0101, "R2 no load without strobe");
   endtask

   task automatic t_trigger();
      int lv[4] = '{1, 4, 8, 14};
      set_ier(4'b0001);
      fifo_en = 1'b1;
      for (int s = 0; s < 4; s++) begin
         for (int d = -1; d <= 1; d++) begin
            @(negedge clk);
            trig_sel = 2'(s);
            rx_count = 5'(lv[s] + d);
            settle();
            chk(irq, (d >= 0), "R3 level compare");
            chk(int_code, (d >= 0) ? 4'b0100 : 4'b0001, "R4 rx code");
         end
      end
      // fall below level: same cycle, no clock edge needed
      @(negedge clk); trig_sel = 2'd2; rx_count = 5'd8; settle();
      chk(irq, 1'b1, "R4 at level");
      rx_count = 5'd7; #1;
      chk(irq, 1'b0, "R4 drop without edge");
      chk(int_code, 4'b0001, "R4 code cleared");
   endtask

   task automatic t_nonfifo();
      @(negedge clk); fifo_en = 1'b0; trig_sel = 2'd3; rx_count = 5'd1; settle();
      chk(irq, 1'b1, "R3 non-FIFO level 1");
      chk(int_code, 4'b0100, "R3 non-FIFO code");
      @(negedge clk); rx_count = 5'd0; settle();
      chk(irq, 1'b0, "R3 non-FIFO empty");
      @(negedge clk); fifo_en = 1'b1; rx_count = 5'd0; trig_sel = 2'd0; settle();
   endtask

   task automatic t_line_err();
      set_ier(4'b0100);
      @(negedge clk); err_evt = 4'b0010; settle();
      chk(lsr[4:1], 4'b0000, "R5 not before edge");
      @(negedge clk); err_evt = '0; settle();
      chk(lsr[4:1], 4'b0010, "R5 parity latched");
      chk(int_code, 4'b0110, "R6 line code");
      chk(irq, 1'b1, "R6 line irq");
      @(negedge clk); settle();
      chk(lsr[4:1], 4'b0010, "R5 held");
      pulse_err(4'b1000, 1'b1);
      chk(lsr[4:1], 4'b1000, "R5 new event wins over read");
      pulse_err(4'b0000, 1'b1);
      chk(lsr[4:1], 4'b0000, "R5 cleared by read");
      chk(irq, 1'b0, "R6 irq after clear");
      pulse_err(4'b0101, 1'b0);
      chk(lsr[4:1], 4'b0101, "R5 overrun+framing");
      set_ier(4'b0000);
      chk(irq, 1'b0, "R6 masked");
      pulse_err(4'b0000, 1'b1);
   endtask

   task automatic t_priority();
      set_ier(4'b1111);
      @(negedge clk);
      fifo_en = 1'b1; trig_sel = 2'd3; rx_count = 5'd14;
      tx_fifo_empty = 1'b1; modem_pend = 1'b1; err_evt = 4'b0001;
      @(negedge clk); err_evt = '0; settle();
      chk(int_code, 4'b0110, "R9 line first");
      pulse_err(4'b0000, 1'b1);
      chk(int_code, 4'b0100, "R9 rx second");
      @(negedge clk); rx_count = 5'd13; settle();
      chk(int_code, 4'b0010, "R7 tx third");
      @(negedge clk); tx_fifo_empty = 1'b0; settle();
      chk(int_code, 4'b0000, "R8 modem code");
      chk(irq, 1'b1, "R10 modem irq");
      @(negedge clk); modem_pend = 1'b0; settle();
      chk(int_code, 4'b0001, "R10 none");
      chk(irq, 1'b0, "R10 irq low");
      @(negedge clk); rx_count = 5'd0; settle();
   endtask

   task automatic t_masks();
      set_ier(4'b0010);
      @(negedge clk); tx_fifo_empty = 1'b1; modem_pend = 1'b1; rx_count = 5'd16; settle();
      chk(int_code, 4'b0010, "R7 only tx enabled");
      set_ier(4'b1000);
      chk(int_code, 4'b0000, "R8 only modem enabled");
   endtask

   task automatic t_polled();
      set_ier(4'b0000);
      @(negedge clk); fifo_en = 1'b1; err_evt = 4'b1111; settle();
      @(negedge clk); err_evt = '0; settle();
      chk(polled, 1'b1, "R11 polled flag");
      chk(irq, 1'b0, "R11 no irq");
      chk(int_code, 4'b0001, "R11 code none");
      @(negedge clk); fifo_en = 1'b0; settle();
      chk(polled, 1'b0, "R11 not polled without FIFO");
      @(negedge clk); fifo_en = 1'b1; settle();
      pulse_err(4'b0000, 1'b1);
   endtask

   task automatic t_lsr_bits();
      @(negedge clk);
      rx_count = 5'd0; tx_fifo_empty = 1'b1; tx_shift_empty = 1'b0; rx_err_any = 1'b1;
      settle();
      chk(lsr, 8'b1010_0000, "R12 lsr pattern A");
      @(negedge clk); rx_count = 5'd3; tx_shift_empty = 1'b1; fifo_en = 1'b0; settle();
      chk(lsr, 8'b0110_0001, "R12 lsr pattern B");
      @(negedge clk); tx_fifo_empty = 1'b0; fifo_en = 1'b1; rx_err_any = 1'b0; settle();
      chk(lsr, 8'b0000_0001, "R12 lsr pattern C");
   endtask

   initial begin : watchdog
      #(20 * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      settle();
      t_reset();
      rst_n = 1'b1;
      t_ier_write();
      t_trigger();
      t_nonfifo();
      t_line_err();
      t_priority();
      t_masks();
      t_polled();
      t_lsr_bits();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule